// File: doc/BRIEF.md
# Jitter Accumulation Sampling Sequencer

This block paces a jitter-based random bit source. While enabled it holds the free-running oscillator on. It counts an accumulation window of a programmable number of system clock cycles, and it fires a one-cycle capture strobe to the delay-line sampler at the end of each window. Each raw bit that comes back from the extractor is folded by XOR into a running parity. Once a programmable number of raw bits has been folded, the parity leaves as one output bit, so with steady traffic one bit leaves every `acc_cycles × fold_rate` clocks.

The raw input has a valid strobe and no ready, because the sampler cannot be stalled. The output is a valid/ready stream. A bit offered on `out_valid` stays put, value unchanged, until `out_ready` is high at a clock edge. A compressed bit that completes while an earlier one is still waiting is discarded, since the randomness of the source does not depend on which bits are kept. A new window length is taken up at the next window boundary. A new fold rate is taken up when the current fold group ends, or when the block is restarted.

Top module: `jitter_acc_sequencer`

## Requirements
- R1: `osc_en` is high in every cycle after the first cycle of `run` high, for as long as `run` stays high. It is low in the cycle after a cycle with `run` low.
- R2: The first `capture` pulse comes in the `acc_cycles`-th cycle in which `osc_en` is high, and later pulses follow every `acc_cycles` cycles. Each pulse lasts one cycle when `acc_cycles` > 1.
- R3: `acc_cycles` = 0 behaves as `acc_cycles` = 1.
- R4: A new `acc_cycles` value written during a window leaves that window's length unchanged and sets the length of the following windows.
- R5: Output bit k equals the XOR of raw bits k·np through k·np+np−1, counted from the start of the run. `out_valid` rises in the cycle after the edge that took the last raw bit of the group.
- R6: `fold_rate` = 1 passes each raw bit straight through, and `fold_rate` = 0 behaves as 1.
- R7: `raw_valid` has no effect while the block is not running, and a stop throws away a partly folded group.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold. Bits completed in that time are dropped.
- R9: After reset, `osc_en`, `capture` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Generator enable |
| acc_cycles | input | NA_W | Accumulation window in clock cycles |
| fold_rate | input | NP_W | Raw bits folded into each output bit |
| raw_bit | input | 1 | Raw bit from the extractor |
| raw_valid | input | 1 | Raw bit strobe |
| out_ready | input | 1 | Consumer accepts the output bit |
| osc_en | output | 1 | Oscillator enable |
| capture | output | 1 | One-cycle sample strobe to the delay lines |
| out_valid | output | 1 | Output bit offered |
| out_bit | output | 1 | Compressed output bit |

## Verification
Some properties are checked on every cycle by the assertions. The oscillator enable drops after `run` falls. The window counter stays within a non-zero limit. The strobe never repeats back to back unless the window is one cycle long. The fold counter stays below its rate. An offered bit holds while it is stalled, and no new bit appears while the block is idle. Other behaviour can only be shown by the bench scenarios, which play the extractor's part: the parity values against known raw patterns, the exact strobe spacing and first-window delay, the point at which a new window length takes hold, and the discard of a partial group on restart.

// File: rtl/jas_pkg.sv
package jas_pkg;
  localparam int DEF_NA_W = 8;
  localparam int DEF_NP_W = 5;

  typedef struct packed {
    logic done;
    logic value;
  } fold_evt_t;
endpackage

// File: rtl/jas_accum_timer.sv
module jas_accum_timer #(
  parameter int NA_W = jas_pkg::DEF_NA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NA_W-1:0] acc_cycles,
  output logic            osc_en,
  output logic            capture
);
  localparam logic [NA_W-1:0] ONE = NA_W'(1);

  logic            active;
  logic [NA_W-1:0] cnt;
  logic [NA_W-1:0] na_q;
  logic [NA_W-1:0] na_eff;

  assign na_eff  = (acc_cycles == '0) ? ONE : acc_cycles;
  assign osc_en  = active;
  assign capture = active && run && (cnt == na_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      na_q   <= ONE;
    end else if (!run) begin
      active <= 1'b0;
      cnt    <= '0;
      na_q   <= ONE;
    end else if (!active) begin
      active <= 1'b1;
      cnt    <= ONE;
      na_q   <= na_eff;
    end else if (cnt == na_q) begin
      cnt    <= ONE;
      na_q   <= na_eff;
    end else begin
      cnt    <= cnt + ONE;
    end
  end

  assert_osc_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !osc_en);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (!capture || na_q == ONE));
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != '0 && cnt <= na_q));
  assert_na_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> na_q != '0);
endmodule

// File: rtl/jas_xor_fold.sv
module jas_xor_fold #(
  parameter int NP_W = jas_pkg::DEF_NP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic [NP_W-1:0]   fold_rate,
  input  logic              in_bit,
  input  logic              in_valid,
  output jas_pkg::fold_evt_t evt
);
  localparam logic [NP_W:0] ONE_X = (NP_W+1)'(1);

  logic [NP_W-1:0] cnt;
  logic [NP_W-1:0] np_q;
  logic [NP_W-1:0] np_eff;
  logic            par;
  logic            take;
  logic            last;

  assign np_eff = (fold_rate == '0) ? NP_W'(1) : fold_rate;
  assign take   = running && in_valid;
  assign last   = ({1'b0, cnt} + ONE_X) == {1'b0, np_q};
  assign evt.done  = take && last;
  assign evt.value = par ^ in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      par  <= 1'b0;
      np_q <= NP_W'(1);
    end else if (!running) begin
      cnt  <= '0;
      par  <= 1'b0;
      np_q <= np_eff;
    end else if (take) begin
      if (last) begin
        cnt  <= '0;
        par  <= 1'b0;
        np_q <= np_eff;
      end else begin
        cnt  <= cnt + NP_W'(1);
        par  <= par ^ in_bit;
      end
    end
  end

  assert_fold_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < np_q);
endmodule

// File: rtl/jas_out_hold.sv
module jas_out_hold (
  input  logic               clk,
  input  logic               rst_n,
  input  jas_pkg::fold_evt_t evt,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (evt.done && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_bit   <= evt.value;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
endmodule

// File: rtl/jitter_acc_sequencer.sv
module jitter_acc_sequencer #(
  parameter int NA_W = jas_pkg::DEF_NA_W,
  parameter int NP_W = jas_pkg::DEF_NP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NA_W-1:0] acc_cycles,
  input  logic [NP_W-1:0] fold_rate,
  input  logic            raw_bit,
  input  logic            raw_valid,
  input  logic            out_ready,
  output logic            osc_en,
  output logic            capture,
  output logic            out_valid,
  output logic            out_bit
);
  jas_pkg::fold_evt_t evt;
  logic               running;

  assign running = run && osc_en;

  jas_accum_timer #(.NA_W(NA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .acc_cycles(acc_cycles),
    .osc_en(osc_en), .capture(capture)
  );

  jas_xor_fold #(.NP_W(NP_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .running(running), .fold_rate(fold_rate),
    .in_bit(raw_bit), .in_valid(raw_valid), .evt(evt)
  );

  jas_out_hold u_out (
    .clk(clk), .rst_n(rst_n), .evt(evt), .out_ready(out_ready),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  assert_idle_no_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && out_valid && out_ready) |=> !out_valid);
endmodule

// File: tb/jitter_acc_sequencer_tb.sv
module jitter_acc_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [7:0] acc_cycles = 8'd1;
  logic [4:0] fold_rate = 5'd1;
  logic       out_ready = 1'b1;
  logic       idle_valid = 1'b0;
  logic       resp_valid = 1'b0;
  logic       resp_bit = 1'b0;
  logic       raw_bit, raw_valid;
  logic       osc_en, capture, out_valid, out_bit;

  assign raw_valid = resp_valid | idle_valid;
  assign raw_bit   = idle_valid ? 1'b1 : resp_bit;

  always #2 clk = ~clk;

  jitter_acc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .acc_cycles(acc_cycles),
    .fold_rate(fold_rate), .raw_bit(raw_bit), .raw_valid(raw_valid),
    .out_ready(out_ready), .osc_en(osc_en), .capture(capture),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  typedef struct packed {
    logic [7:0]  na;
    logic [4:0]  np;
    logic [63:0] pat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  5'd7,  64'hC3A5_1F0E_9B72_46D8},
    '{8'd2,  5'd6,  64'h5A0F_E13C_7788_2B94},
    '{8'd5,  5'd10, 64'h0123_4567_89AB_CDEF},
    '{8'd10, 5'd13, 64'hFEDC_BA98_7654_3210},
    '{8'd20, 5'd1,  64'h0000_0000_0000_00B6},
    '{8'd0,  5'd0,  64'h0000_0000_0000_005C},
    '{8'd3,  5'd2,  64'h0000_0000_0000_00E4}
  };

  int          n_tests = 0;
  int          n_fail  = 0;
  int          cyc = 0;
  int          idx = 0;
  logic [63:0] cur_pat = '0;
  int          osc_t = 0;
  logic        osc_prev = 1'b0;
  int          ncap = 0;
  int          nout = 0;
  int          cap_t [128];
  int          out_t [128];
  logic        out_b [128];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [63:0] p, input int s, input int n);
    logic r = 1'b0;
    for (int i = 0; i < n; i++) r ^= p[s+i];
    return r;
  endfunction

  // extractor model and monitor, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    resp_valid = capture;
    if (capture) begin
      resp_bit = cur_pat[idx[5:0]];
      idx++;
    end
    if (osc_en && !osc_prev) osc_t = cyc;
    osc_prev = osc_en;
    if (capture && ncap < 128) begin cap_t[ncap] = cyc; ncap++; end
    if (out_valid && out_ready && nout < 128) begin
      out_b[nout] = out_bit; out_t[nout] = cyc; nout++;
    end
    if (cyc > 150000) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic clear_log(input logic [63:0] p);
    cur_pat = p; idx = 0; ncap = 0; nout = 0;
  endtask

  task automatic wait_out(input int n);
    for (int i = 0; i < 4000 && nout < n; i++) step(1);
  endtask

  initial begin
    step(3);
    // R9: reset state
    chk(osc_en == 1'b0, "R9 osc_en", osc_en, 0);
    chk(capture == 1'b0, "R9 capture", capture, 0);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    rst_n = 1'b1;
    step(2);

    // table walk: R2 R3 R5 R6
    for (int v = 0; v < NV; v++) begin
      int na_e, np_e;
      na_e = (VEC[v].na == 0) ? 1 : int'(VEC[v].na);
      np_e = (VEC[v].np == 0) ? 1 : int'(VEC[v].np);
      run = 1'b0; acc_cycles = VEC[v].na; fold_rate = VEC[v].np;
      step(2);
      clear_log(VEC[v].pat);
      run = 1'b1;
      wait_out(4);
      run = 1'b0;
      for (int j = 0; j < 4; j++)
        chk(out_b[j] == exp_par(VEC[v].pat, j*np_e, np_e),
            (np_e == 1) ? "R6 passthrough bit" : "R5 folded bit",
            out_b[j], exp_par(VEC[v].pat, j*np_e, np_e));
      chk(cap_t[0] - osc_t == na_e - 1,
          (VEC[v].na == 0) ? "R3 first strobe" : "R2 first strobe",
          cap_t[0] - osc_t, na_e - 1);
      chk(cap_t[1] - cap_t[0] == na_e, "R2 strobe spacing", cap_t[1] - cap_t[0], na_e);
      chk(out_t[0] - cap_t[np_e-1] == 1, "R5 output latency", out_t[0] - cap_t[np_e-1], 1);
    end

    // R1: enable held while running, dropped after stop
    acc_cycles = 8'd4; fold_rate = 5'd3; clear_log(64'h1234);
    run = 1'b1; step(1);
    begin
      int lows = 0;
      for (int i = 0; i < 30; i++) begin if (!osc_en) lows++; step(1); end
      chk(lows == 0, "R1 osc_en held", lows, 0);
    end
    run = 1'b0; step(1);
    chk(osc_en == 1'b0, "R1 osc_en drop", osc_en, 0);
    step(2);

    // R4: window length change applies from the next window
    acc_cycles = 8'd3; fold_rate = 5'd2; clear_log(64'h0F);
    run = 1'b1;
    for (int i = 0; i < 100 && ncap < 1; i++) step(1);
    acc_cycles = 8'd6;
    for (int i = 0; i < 100 && ncap < 3; i++) step(1);
    run = 1'b0;
    chk(cap_t[1] - cap_t[0] == 3, "R4 current window", cap_t[1] - cap_t[0], 3);
    chk(cap_t[2] - cap_t[1] == 6, "R4 next window", cap_t[2] - cap_t[1], 6);
    step(3);

    // R7: raw strobes while idle are ignored
    acc_cycles = 8'd1; fold_rate = 5'd2; clear_log(64'h0000_0000_0000_0006);
    idle_valid = 1'b1; step(3); idle_valid = 1'b0; step(2);
    chk(nout == 0, "R7 idle output count", nout, 0);
    run = 1'b1; wait_out(1); run = 1'b0;
    chk(out_b[0] == exp_par(64'h6, 0, 2), "R7 clean after idle", out_b[0], exp_par(64'h6, 0, 2));
    step(3);

    // R7: a stop discards a partial group
    acc_cycles = 8'd2; fold_rate = 5'd3; clear_log(64'h0000_0000_0000_0007);
    run = 1'b1;
    for (int i = 0; i < 100 && ncap < 2; i++) step(1);
    step(1);
    run = 1'b0; step(3);
    chk(nout == 0, "R7 partial group no output", nout, 0);
    clear_log(64'h0000_0000_0000_0001);
    run = 1'b1; wait_out(1); run = 1'b0;
    chk(out_b[0] == 1'b1, "R7 restart parity", out_b[0], 1);
    step(3);

    // R8: back-pressure holds the first bit and drops later ones
    acc_cycles = 8'd1; fold_rate = 5'd1; clear_log(64'h0000_0000_0000_0AA9);
    out_ready = 1'b0; run = 1'b1; step(6);
    chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
    chk(out_bit == 1'b1, "R8 bit held early", out_bit, 1);
    step(6);
    chk(out_bit == 1'b1, "R8 bit held late", out_bit, 1);
    chk(nout == 0, "R8 nothing accepted", nout, 0);
    out_ready = 1'b1; step(2);
    run = 1'b0;
    chk(out_b[0] == 1'b1, "R8 held bit delivered", out_b[0], 1);
    step(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule